// File: doc/BRIEF.md
# Multi-Channel 33-Level PWM Generator

The block drives a bank of output channels with pulse-width modulation for LED brightness. Every channel has its own 6-bit brightness code. One shared period counter serves all channels. A period has 32 steps. A code of 0 keeps the channel dark. A code k from 1 to 31 lights it for k of the 32 steps. Any code of 32 or more keeps it lit for the whole period. This gives 33 distinct brightness levels.

The counter advances on a slow timing tick. That tick comes either from an internal source or from an external oscillator strobe, and a configuration bit chooses which one.

- A brightness code is taken into a channel only when a period starts, so changing a code never produces a cut-short pulse.
- An active-low reset input can restart the period counter, but only while a separate option bit allows it.
- A channel whose enable is low holds its output low.

Top module: `pwm_bank`

## Requirements
- R1: A channel whose active code is 0 drives its output low on every cycle.
- R2: A channel whose active code is k, with 1 <= k <= 31, is high on exactly k of every 32 consecutive timing ticks. It is high while the counter value is below k.
- R3: A channel whose active code is 32 or more (up to 63) drives its output high on every cycle.
- R4: The period counter runs 0..31 and wraps to 0. It advances by one only on a selected timing tick and otherwise holds its value.
- R5: When `src_internal` is 1, `int_tick` is the timing tick. When it is 0, `ext_tick` is the timing tick. The unselected strobe has no effect.
- R6: When `pin_rst_n` is low and `cnt_clr_en` is 1, the counter is forced to 0 and the codes are reloaded. When `cnt_clr_en` is 0, `pin_rst_n` has no effect.
- R7: A new code on `code_flat` is taken into a channel only at a period boundary or during a counter clear. This boundary is a selected tick while the counter is 31.
- R8: A channel whose `ch_en` bit is 0 drives its output low.
- R9: A synchronous active-high `rst` sets the counter to 0, every active code to 0 and every output to low. Outputs are registered and follow the counter one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal timing strobe, one cycle per tick |
| ext_tick | input | 1 | External oscillator strobe, one cycle per tick |
| src_internal | input | 1 | 1 selects int_tick, 0 selects ext_tick |
| pin_rst_n | input | 1 | Active-low counter restart request (synchronous to clk) |
| cnt_clr_en | input | 1 | 1 lets pin_rst_n clear the counter |
| ch_en | input | NUM_CH | Per-channel output enable |
| code_flat | input | NUM_CH*CODE_W | Packed brightness codes; channel i at bits [i*CODE_W +: CODE_W] |
| pwm_out | output | NUM_CH | Registered PWM outputs |

## Verification
Channel 0 is swept through every code from 0 to 33, and then through 63. The other channels hold fixed codes: 0, 1, 15, 16, 31, 32, 40 and 63. These values separate the two extremes from the edge fractional duties at 1/32 and 31/32. The high count is measured over 32 ticks for each code.

Code changes are made at arbitrary points in a period. A reference model, compared on every clock, catches any update that takes effect mid-period.

The strobe source is switched while the unselected strobe keeps toggling. This shows whether the counter freezes or advances on the wrong tick. Pin-reset pulses are applied with the option bit both off and on, to tell an ignored restart from an honoured one. Channel enables are dropped under a full-on code to separate enable gating from the code path.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Compare rule shared by every channel: lit while the step index
  // is below the code; codes at or beyond the period length are full on.
  function automatic logic duty_high(input int unsigned code,
                                     input int unsigned step,
                                     input int unsigned period);
    duty_high = (code >= period) || (step < code);
  endfunction

endpackage

// File: rtl/pwm_tick_sel.sv
module pwm_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic int_tick,
  input  logic ext_tick,
  input  logic src_internal,
  output logic tick_q
);

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= src_internal ? int_tick : ext_tick;
  end

  // R5
  sel_int_chk: assert property (@(posedge clk) disable iff (rst)
    (src_internal && !$past(rst)) |=> (tick_q == $past(int_tick)));

  // R5
  sel_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (!src_internal && !$past(rst)) |=> (tick_q == $past(ext_tick)));

endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int PERIOD = 32,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic at_end;

  always_comb begin
    at_end = tick && (cnt == LAST);
    load   = at_end || clr;
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (at_end) cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !tick && !$past(rst)) |=> $stable(cnt));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && tick && cnt == LAST) |=> (cnt == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CODE_W = 6,
  parameter int PERIOD = 32,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              en,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CNT_W-1:0]  cnt,
  output logic              out_q
);
  import pwm_pkg::*;

  logic [CODE_W-1:0] code_act;
  logic              lit;

  always_ff @(posedge clk) begin
    if (rst)       code_act <= '0;
    else if (load) code_act <= code_in;
  end

  always_comb lit = duty_high(int'(code_act), int'(cnt), PERIOD);

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= en & lit;
  end

  // R8
  dis_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_q);

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !$past(rst)) |=> $stable(code_act));

  // R1
  zero_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (code_act == '0) |=> !out_q);

  // R3
  full_on_chk: assert property (@(posedge clk) disable iff (rst)
    (en && code_act >= CODE_W'(PERIOD)) |=> out_q);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NUM_CH = 9,
  parameter int CODE_W = 6,
  parameter int PERIOD = 32,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     int_tick,
  input  logic                     ext_tick,
  input  logic                     src_internal,
  input  logic                     pin_rst_n,
  input  logic                     cnt_clr_en,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH*CODE_W-1:0] code_flat,
  output logic [NUM_CH-1:0]        pwm_out
);

  logic             tick_q;
  logic             clr;
  logic             load;
  logic [CNT_W-1:0] cnt;

  always_comb clr = cnt_clr_en & ~pin_rst_n;

  pwm_tick_sel u_tick (
    .clk          (clk),
    .rst          (rst),
    .int_tick     (int_tick),
    .ext_tick     (ext_tick),
    .src_internal (src_internal),
    .tick_q       (tick_q)
  );

  pwm_period_cnt #(.PERIOD(PERIOD)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_q),
    .clr  (clr),
    .cnt  (cnt),
    .load (load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CODE_W(CODE_W), .PERIOD(PERIOD)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .load    (load),
      .en      (ch_en[g]),
      .code_in (code_flat[g*CODE_W +: CODE_W]),
      .cnt     (cnt),
      .out_q   (pwm_out[g])
    );
  end

  // R9
  rst_dark_chk: assert property (@(posedge clk)
    rst |=> (pwm_out == '0));

endmodule

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
  localparam int NUM_CH = 9;
  localparam int CODE_W = 6;
  localparam int PERIOD = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic int_tick = 1'b0, ext_tick = 1'b0, src_internal = 1'b1;
  logic pin_rst_n = 1'b1, cnt_clr_en = 1'b0;
  logic [NUM_CH-1:0] ch_en = '1;
  logic [NUM_CH*CODE_W-1:0] code_flat = '0;
  logic [NUM_CH-1:0] pwm_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .PERIOD(PERIOD)) dut_i (
    .clk(clk), .rst(rst), .int_tick(int_tick), .ext_tick(ext_tick),
    .src_internal(src_internal), .pin_rst_n(pin_rst_n), .cnt_clr_en(cnt_clr_en),
    .ch_en(ch_en), .code_flat(code_flat), .pwm_out(pwm_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: tick stage, step counter, per-channel codes, outputs.
  int  m_step = 0;
  bit  m_tick = 0;
  int  m_code[NUM_CH];
  bit  m_out[NUM_CH];

  always @(posedge clk) begin
    bit nt, reload, boundary;
    int ns;
    if (rst) begin
      m_step = 0; m_tick = 0;
      foreach (m_code[i]) begin m_code[i] = 0; m_out[i] = 0; end
    end else begin
      boundary = m_tick && (m_step == PERIOD-1);
      reload = boundary || (cnt_clr_en && !pin_rst_n);
      foreach (m_out[i])
        m_out[i] = ch_en[i] && ((m_code[i] >= PERIOD) || (m_step < m_code[i]));
      if (cnt_clr_en && !pin_rst_n) ns = 0;
      else if (m_tick) ns = (m_step + 1) % PERIOD;
      else ns = m_step;
      nt = src_internal ? int_tick : ext_tick;
      if (reload)
        foreach (m_code[i]) m_code[i] = int'(code_flat[i*CODE_W +: CODE_W]);
      m_step = ns; m_tick = nt;
    end
  end

  // Every-clock comparison against the model covers R2, R4, R5, R6 and R7.
  always @(negedge clk) begin
    if (!rst && !done)
      for (int i = 0; i < NUM_CH; i++)
        if (pwm_out[i] !== m_out[i])
          chk(0, "R2/R4/R5/R6/R7 model", int'(pwm_out[i]), int'(m_out[i]));
        else
          n_chk++;
  end

  task automatic set_code(input int ch, input int v);
    code_flat[ch*CODE_W +: CODE_W] = CODE_W'(v);
  endtask

  task automatic count_high(input int ch, input int exp, input string req);
    int n = 0;
    repeat (PERIOD) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
    chk(n == exp, req, n, exp);
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int fixed[NUM_CH];
    fixed = '{0, 0, 1, 15, 16, 31, 32, 40, 63};
    foreach (fixed[i]) set_code(i, fixed[i]);
    repeat (4) @(negedge clk);
    // R9 outputs low in reset
    chk(pwm_out == '0, "R9 reset", int'(pwm_out), 0);
    rst = 0;
    int_tick = 1;
    repeat (3) @(negedge clk);
    // R9 codes reset to zero: dark until the first boundary
    chk(pwm_out == '0, "R9 code reset", int'(pwm_out), 0);
    repeat (70) @(negedge clk);
    count_high(1, 0,  "R1 code0");
    count_high(2, 1,  "R2 code1");
    count_high(3, 15, "R2 code15");
    count_high(5, 31, "R2 code31");
    count_high(6, 32, "R3 code32");
    count_high(8, 32, "R3 code63");

    // Sweep channel 0 through every level.
    for (int k = 0; k <= 34; k++) begin
      int v, e;
      v = (k == 34) ? 63 : k;
      e = (v >= 32) ? 32 : v;
      set_code(0, v);
      repeat (67) @(negedge clk);
      count_high(0, e, (v == 0) ? "R1 sweep" : (v >= 32) ? "R3 sweep" : "R2 sweep");
    end

    // R8 disable under full-on code
    ch_en[8] = 0;
    repeat (2) @(negedge clk);
    count_high(8, 0, "R8 disabled");
    ch_en[8] = 1;

    // R5 external source selected, external strobe idle: counter freezes
    set_code(0, 16);
    repeat (70) @(negedge clk);
    src_internal = 0; ext_tick = 0;
    repeat (3) @(negedge clk);
    begin
      logic [NUM_CH-1:0] snap;
      snap = pwm_out;
      repeat (40) @(negedge clk);
      chk(pwm_out == snap, "R5 frozen", int'(pwm_out), int'(snap));
    end
    // R5 slow external strobe, toggling internal strobe ignored
    for (int t = 0; t < 200; t++) begin
      ext_tick = (t % 3 == 0);
      int_tick = (t % 2 == 0);
      @(negedge clk);
    end
    ext_tick = 0; src_internal = 1; int_tick = 1;

    // R7 mid-period code changes
    for (int t = 0; t < 6; t++) begin
      repeat (7 + t*5) @(negedge clk);
      set_code(4, (t*11) % 40);
    end
    repeat (80) @(negedge clk);

    // R6 pin reset ignored when option off
    cnt_clr_en = 0;
    repeat (10) @(negedge clk);
    pin_rst_n = 0;
    repeat (5) @(negedge clk);
    pin_rst_n = 1;
    repeat (40) @(negedge clk);
    // R6 pin reset honoured when option on
    cnt_clr_en = 1;
    repeat (13) @(negedge clk);
    set_code(3, 5);
    pin_rst_n = 0;
    repeat (4) @(negedge clk);
    pin_rst_n = 1;
    repeat (2) @(negedge clk);
    count_high(3, 5, "R6 restart");
    repeat (40) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule